// File: doc/BRIEF.md
# Memory Data-Bus Line Tester

This block is a hardware sequencer that checks the data bus of a synchronous single-port RAM for shorted and open lines. It runs before any deeper memory test. After a start pulse it steps through a fixed set of 64-bit patterns. Every pair of neighbouring data bits takes opposite values in at least one pattern.

For each pattern the engine works in three steps:
1. It writes the pattern to a target word.
2. It writes a fixed decoy word to the next address up. This drives the bus to a different value, so charge held on a floating line cannot pass for a good read.
3. It reads the target once and compares the captured word with the pattern.

A mismatch does not stop the run. The engine keeps a record of the first mismatch only, holding the address, the expected word and the observed word. It pulses done when all patterns have been tried.

Top module: `data_line_tester`

## Requirements
- R1: After reset the engine is idle: busy, done, fail, memWe and memRe are 0, and the failure record (failAddr, failExp, failObs) is all zero.
- R2: The engine applies 12 patterns, index 0 first, in this order:
  - AAAAAAAAAAAAAAAA
  - CCCCCCCCCCCCCCCC
  - F0F0F0F0F0F0F0F0
  - FF00FF00FF00FF00
  - FFFF0000FFFF0000
  - FFFFFFFF00000000
  - 00000000FFFFFFFF
  - 0000FFFF0000FFFF
  - 00FF00FF00FF00FF
  - 0F0F0F0F0F0F0F0F
  - 3333333333333333
  - 5555555555555555
- R3: For each pattern the memory sees three operations in consecutive cycles, in this order:
  - a write of the pattern to baseAddr (latched at start);
  - a write of 0x0123456789ABCDEF to baseAddr+1;
  - a read strobe at baseAddr.
- R4: Read data is sampled exactly RD_LAT cycles after the cycle in which memRe is high.
- R5: The target is read exactly once per pattern, so a run makes 12 reads and 24 writes.
- R6: A mismatch does not end the run. All 12 patterns are applied, and fail is 1 at the end of the run if any comparison mismatched.
- R7: The failure record holds the target address, the pattern and the single captured read word of the first mismatch only. Later mismatches leave it unchanged.
- R8: done is high for exactly one cycle, in the cycle after the last comparison. busy is high from the cycle after start is accepted through that done cycle.
- R9: A start pulse while busy is high is ignored: the run is neither restarted nor extended.
- R10: An accepted start clears fail and the failure record.
- R11: memWe and memRe are never high together, and both stay low while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| baseAddr | input | ADDR_W | Target word address, latched at start |
| memRData | input | DATA_W | RAM read data, valid RD_LAT cycles after the read strobe |
| memAddr | output | ADDR_W | RAM word address |
| memWData | output | DATA_W | RAM write data |
| memWe | output | 1 | RAM write enable |
| memRe | output | 1 | RAM read strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Some pattern mismatched in the current or last run |
| failAddr | output | ADDR_W | Address of first mismatch |
| failExp | output | DATA_W | Pattern written at first mismatch |
| failObs | output | DATA_W | Word read back at first mismatch |

## Verification
The engine is tried against a RAM model with four behaviours, each pointing at a different fault:
- A healthy memory must give a clean pass with the exact operation sequence.
- A floating bus returns the last driven word. It must be caught on the first pattern with the decoy word as the observed value.
- A data bit stuck at 0 must first show on the first complemented pattern.
- Two bits wired together as an AND short must show on the alternating pattern.

Further runs cover three more cases:
- a restart after a failing run, which must clear the record;
- a start pulse in the middle of a run, which must be ignored;
- a non-default read latency, which checks that the sample lands in the right cycle.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_TGT,
    ST_WR_DEC,
    ST_READ,
    ST_WAIT,
    ST_DONE
  } dltState_t;

  typedef struct packed {
    logic clearRun;
    logic wrTgt;
    logic wrDecoy;
    logic rdStrobe;
    logic sample;
    logic advance;
  } dltStrobes_t;

endpackage

// File: rtl/dlt_ctrl.sv
module dlt_ctrl
  import dlt_pkg::*;
#(
  parameter int RD_LAT = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        lastPat,
  output dltStrobes_t strb,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = (RD_LAT < 2) ? 1 : $clog2(RD_LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_LAT - 1);

  dltState_t        state;
  logic [CNT_W-1:0] waitCnt;
  logic             waitEnd;

  assign waitEnd = (state == ST_WAIT) && (waitCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE:   if (start) state <= ST_WR_TGT;
        ST_WR_TGT: state <= ST_WR_DEC;
        ST_WR_DEC: state <= ST_READ;
        ST_READ: begin
          state   <= ST_WAIT;
          waitCnt <= '0;
        end
        ST_WAIT: begin
          if (waitEnd) state <= lastPat ? ST_DONE : ST_WR_TGT;
          else         waitCnt <= waitCnt + 1'b1;
        end
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.clearRun = (state == ST_IDLE) && start;
    strb.wrTgt    = (state == ST_WR_TGT);
    strb.wrDecoy  = (state == ST_WR_DEC);
    strb.rdStrobe = (state == ST_READ);
    strb.sample   = waitEnd;
    strb.advance  = waitEnd && !lastPat;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // R3
  decoy_after_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTgt |=> strb.wrDecoy);
  // R3
  read_after_decoy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDecoy |=> strb.rdStrobe);
  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  start_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> !strb.wrTgt || $past(strb.sample));

endmodule

// File: rtl/dlt_datapath.sv
module dlt_datapath
  import dlt_pkg::*;
#(
  parameter int               ADDR_W = 16,
  parameter int               DATA_W = 64,
  parameter logic [DATA_W-1:0] DECOY = 64'h0123456789ABCDEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dltStrobes_t       strb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] memRData,
  output logic              lastPat,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              memWe,
  output logic              memRe,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs
);
  localparam int HALF    = $clog2(DATA_W);
  localparam int NUM_PAT = 2 * HALF;
  localparam int IDX_W   = $clog2(NUM_PAT);

  logic [ADDR_W-1:0] baseQ;
  logic [IDX_W-1:0]  patIdx;
  logic [DATA_W-1:0] curPat;

  // Block size 2^k alternating pattern; the second half is the inverse
  // of the first, walked back from the widest block.
  function automatic logic [DATA_W-1:0] patternAt(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] p;
    int k;
    logic inv;
    if (int'(idx) < HALF) begin
      k   = int'(idx);
      inv = 1'b0;
    end else begin
      k   = NUM_PAT - 1 - int'(idx);
      inv = 1'b1;
    end
    for (int b = 0; b < DATA_W; b++) p[b] = ((b >> k) & 1) != 0;
    return inv ? ~p : p;
  endfunction

  assign curPat   = patternAt(patIdx);
  assign lastPat  = (patIdx == IDX_W'(NUM_PAT - 1));
  assign memWe    = strb.wrTgt | strb.wrDecoy;
  assign memRe    = strb.rdStrobe;
  assign memAddr  = strb.wrDecoy ? baseQ + 1'b1 : baseQ;
  assign memWData = strb.wrDecoy ? DECOY : curPat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ    <= '0;
      patIdx   <= '0;
      fail     <= 1'b0;
      failAddr <= '0;
      failExp  <= '0;
      failObs  <= '0;
    end else if (strb.clearRun) begin
      baseQ    <= baseAddr;
      patIdx   <= '0;
      fail     <= 1'b0;
      failAddr <= '0;
      failExp  <= '0;
      failObs  <= '0;
    end else begin
      if (strb.sample && (memRData != curPat)) begin
        fail <= 1'b1;
        if (!fail) begin
          failAddr <= baseQ;
          failExp  <= curPat;
          failObs  <= memRData;
        end
      end
      if (strb.advance) patIdx <= patIdx + 1'b1;
    end
  end

  // R11
  no_we_re_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));
  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strb.clearRun) |=> fail);
  // R7
  first_record_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strb.clearRun) |=> ($stable(failAddr) && $stable(failExp) && $stable(failObs)));
  // R10
  start_clears_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearRun |=> !fail);

endmodule

// File: rtl/data_line_tester.sv
module data_line_tester
  import dlt_pkg::*;
#(
  parameter int               ADDR_W = 16,
  parameter int               DATA_W = 64,
  parameter int               RD_LAT = 1,
  parameter logic [DATA_W-1:0] DECOY = 64'h0123456789ABCDEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              memWe,
  output logic              memRe,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs
);
  dltStrobes_t strb;
  logic        lastPat;

  dlt_ctrl #(.RD_LAT(RD_LAT)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lastPat(lastPat),
    .strb(strb), .busy(busy), .done(done)
  );

  dlt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECOY(DECOY)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .baseAddr(baseAddr),
    .memRData(memRData), .lastPat(lastPat), .memAddr(memAddr),
    .memWData(memWData), .memWe(memWe), .memRe(memRe), .fail(fail),
    .failAddr(failAddr), .failExp(failExp), .failObs(failObs)
  );

  // R11
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memWe || memRe));

endmodule

// File: tb/test_data_line_tester.sv
module test_data_line_tester;
  localparam int AW  = 16;
  localparam int DW  = 64;
  localparam int LAT = 2;
  localparam logic [DW-1:0] DEC = 64'h0123456789ABCDEF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [DW-1:0] memRData;
  logic [AW-1:0] memAddr, failAddr;
  logic [DW-1:0] memWData, failExp, failObs;
  logic memWe, memRe, busy, done, fail;

  always #4 clk = ~clk;

  data_line_tester #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) i_data_line_tester (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData),
    .memWe(memWe), .memRe(memRe), .busy(busy), .done(done), .fail(fail),
    .failAddr(failAddr), .failExp(failExp), .failObs(failObs)
  );

  logic [DW-1:0] patTab [0:11];
  initial begin
    patTab[0]  = 64'hAAAAAAAAAAAAAAAA; patTab[1]  = 64'hCCCCCCCCCCCCCCCC;
    patTab[2]  = 64'hF0F0F0F0F0F0F0F0; patTab[3]  = 64'hFF00FF00FF00FF00;
    patTab[4]  = 64'hFFFF0000FFFF0000; patTab[5]  = 64'hFFFFFFFF00000000;
    patTab[6]  = 64'h00000000FFFFFFFF; patTab[7]  = 64'h0000FFFF0000FFFF;
    patTab[8]  = 64'h00FF00FF00FF00FF; patTab[9]  = 64'h0F0F0F0F0F0F0F0F;
    patTab[10] = 64'h3333333333333333; patTab[11] = 64'h5555555555555555;
  end

  // RAM model: fault modes 0 good, 1 floating bus, 2 bit0 stuck-at-0, 3 bits0/1 AND-short
  int            faultMode = 0;
  logic [DW-1:0] ram [0:15];
  logic [DW-1:0] pipe [0:LAT];
  logic [DW-1:0] lastW = '0;
  int            opN = 0;
  int            opK [0:63];
  logic [AW-1:0] opA [0:63];
  logic [DW-1:0] opD [0:63];
  int            doneCnt = 0;
  int            badOverlap = 0;
  int            badIdle = 0;

  initial begin
    for (int i = 0; i < 16; i++) ram[i] = '0;
    for (int i = 0; i <= LAT; i++) pipe[i] = '0;
  end

  assign memRData = pipe[LAT];

  always @(negedge clk) begin
    logic [DW-1:0] v;
    for (int k = LAT; k > 0; k--) pipe[k] = pipe[k-1];
    pipe[0] = '0;
    if (done) doneCnt++;
    if (memWe && memRe) badOverlap++;
    if (!busy && (memWe || memRe)) badIdle++;
    if (memWe) begin
      ram[memAddr[3:0]] = memWData;
      lastW = memWData;
      if (opN < 64) begin opK[opN] = 1; opA[opN] = memAddr; opD[opN] = memWData; end
      opN++;
    end
    if (memRe) begin
      v = ram[memAddr[3:0]];
      if (faultMode == 1) v = lastW;
      if (faultMode == 2) v[0] = 1'b0;
      if (faultMode == 3) begin v[0] = v[0] & v[1]; v[1] = v[0]; end
      pipe[0] = v;
      if (opN < 64) begin opK[opN] = 2; opA[opN] = memAddr; opD[opN] = '0; end
      opN++;
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOnce(input logic [AW-1:0] base, input bool_midStart);
    @(negedge clk);
    opN = 0; doneCnt = 0; baseAddr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", DW'(busy), 1);
    if (bool_midStart) begin
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int c = 0; c < 400 && doneCnt == 0; c++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic checkSeq(input logic [AW-1:0] base, input string tag);
    chk(opN == 36, {"R5 op count ", tag}, DW'(opN), 36);
    chk(doneCnt == 1, {"R8 done cycles ", tag}, DW'(doneCnt), 1);
    chk(busy == 1'b0, {"R8 busy low after done ", tag}, DW'(busy), 0);
    for (int i = 0; i < 12 && opN == 36; i++) begin
      bit ok;
      ok = opK[3*i] == 1 && opA[3*i] == base && opD[3*i] == patTab[i] &&
           opK[3*i+1] == 1 && opA[3*i+1] == base + 1'b1 && opD[3*i+1] == DEC &&
           opK[3*i+2] == 2 && opA[3*i+2] == base;
      chk(ok, {"R2 R3 pattern step ", tag}, opD[3*i], patTab[i]);
    end
  endtask

  task automatic t_reset;
    chk(!busy && !done && !fail && !memWe && !memRe, "R1 idle outputs",
        DW'({busy, done, fail, memWe, memRe}), 0);
    chk(failAddr == '0 && failExp == '0 && failObs == '0, "R1 record clear",
        failExp | failObs | DW'(failAddr), 0);
  endtask

  task automatic t_good;
    faultMode = 0;
    runOnce(16'h0005, 1'b0);
    checkSeq(16'h0005, "good");
    chk(fail == 1'b0, "R6 R4 good memory passes", DW'(fail), 0);
  endtask

  task automatic t_float;
    faultMode = 1;
    runOnce(16'h0009, 1'b0);
    checkSeq(16'h0009, "float");
    chk(fail == 1'b1, "R6 floating bus fails", DW'(fail), 1);
    chk(failAddr == 16'h0009, "R7 float addr", DW'(failAddr), 64'h9);
    chk(failExp == patTab[0], "R7 float exp", failExp, patTab[0]);
    chk(failObs == DEC, "R7 float obs", failObs, DEC);
  endtask

  task automatic t_stuck;
    faultMode = 2;
    runOnce(16'h0003, 1'b0);
    checkSeq(16'h0003, "stuck");
    chk(fail == 1'b1, "R6 stuck fails", DW'(fail), 1);
    chk(failExp == patTab[6], "R7 stuck first exp", failExp, patTab[6]);
    chk(failObs == 64'h00000000FFFFFFFE, "R7 stuck obs", failObs, 64'h00000000FFFFFFFE);
  endtask

  task automatic t_bridge;
    faultMode = 3;
    runOnce(16'h000C, 1'b0);
    chk(fail == 1'b1, "R6 short fails", DW'(fail), 1);
    chk(failExp == patTab[0], "R7 short exp", failExp, patTab[0]);
    chk(failObs == 64'hAAAAAAAAAAAAAAA8, "R7 short obs", failObs, 64'hAAAAAAAAAAAAAAA8);
  endtask

  task automatic t_restart;
    faultMode = 0;
    runOnce(16'h0005, 1'b0);
    chk(fail == 1'b0, "R10 restart clears fail", DW'(fail), 0);
    chk(failAddr == '0 && failExp == '0 && failObs == '0, "R10 record cleared",
        failExp | failObs | DW'(failAddr), 0);
  endtask

  task automatic t_midStart;
    faultMode = 0;
    runOnce(16'h0002, 1'b1);
    checkSeq(16'h0002, "R9 midstart");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_float();
    t_stuck();
    t_bridge();
    t_restart();
    t_midStart();
    chk(badOverlap == 0, "R11 we/re overlap", DW'(badOverlap), 0);
    chk(badIdle == 0, "R11 idle bus quiet", DW'(badIdle), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule